// File: doc/BRIEF.md
# Three-Wire Ternary State Encoder

This block drives a group of three wires (A, B, C) with three-level signalling, one symbol per unit interval. At every interval the three wires sit at three different levels (one high, one mid, one low), so the group is always in one of six wire states. Each input symbol carries a value from 0 to 4. The symbol does not name a level. It names a move from the present wire state to one of the five other states. Every accepted symbol therefore forces at least one wire to change, and a receiver can recover timing from that change.

Upstream logic offers symbols on a valid/ready handshake, one per clock, where one clock is one unit interval. For each wire the block produces a registered pull-up bit and a registered pull-down bit for a voltage-mode driver. The mid level has a code of its own and is driven actively. If no legal symbol arrives in a cycle, the block keeps the present state and drops its activity flag. Word-to-symbol mapping and all analog concerns are outside this block.

Top module: `tri_wire_encoder`

## Requirements
- R1: While `rst` is high, the state is 0: A high, B mid, C low. `sym_active` and `sym_ready` are low.
- R2: Each wire's drive pair {pull-up, pull-down} is 2'b10 for high, 2'b01 for low and 2'b11 for mid. The pair 2'b00 (released) never appears on any wire.
- R3: In every cycle the three wires carry three different levels, one of each, so the group's average level stays constant.
- R4: The state number sets the levels on (A,B,C) as follows: 0=(H,M,L), 1=(M,H,L), 2=(L,H,M), 3=(L,M,H), 4=(M,L,H), 5=(H,L,M). Wire index 0 is A, 1 is B and 2 is C in `wire_pu`, `wire_pd`.
- R5: A symbol s (0..4) is accepted on an edge where `sym_valid` and `sym_ready` are both high. After that edge the state is (previous state + s + 1) mod 6, and the wires and `state_out` show it.
- R6: Each accepted symbol moves to a state different from the previous one, and `sym_active` is high for the cycle after acceptance.
- R7: In a cycle with `sym_valid` low, the state and all wire codes are held and `sym_active` goes low after the edge.
- R8: A symbol value of 5, 6 or 7 is ignored even when offered with `sym_valid` high. The state is held and `sym_active` goes low.
- R9: `sym_ready` is high from the first edge after reset release on, so back-to-back symbols are taken one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one unit interval per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | A symbol is offered |
| sym_ready | output | 1 | The block can take a symbol this cycle |
| sym_data | input | SYM_W | Symbol value, legal range 0..4 |
| wire_pu | output | 3 | Pull-up enables, index 0=A, 1=B, 2=C |
| wire_pd | output | 3 | Pull-down enables, index 0=A, 1=B, 2=C |
| sym_active | output | 1 | A symbol was taken on the last edge |
| state_out | output | 3 | Current wire-state number 0..5 |

## Verification
The bench uses the default parameters: a 3-bit symbol field and reset state 0. The 3-bit field lets the bench offer the codes 5 to 7, so the ignore path for out-of-range symbols is exercised. Reset state 0 makes the first state known, so every later state can be predicted. Symbol streams that include the mod-6 wrap (a large symbol from state 5) and a long run of symbol 0 walk through all six states. Idle gaps and illegal codes are placed between accepted symbols to check that the state holds.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int NUM_STATES = 6;
  localparam int NUM_SYMS   = NUM_STATES - 1;
  localparam int STATE_W    = $clog2(NUM_STATES);
  localparam int NUM_WIRES  = 3;

  // Drive code {pull_up, pull_down}
  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10,
    LVL_MID  = 2'b11
  } lvl_t;

  typedef logic [STATE_W-1:0] state_t;
  typedef lvl_t [NUM_WIRES-1:0] triple_t;  // [0]=A [1]=B [2]=C

  function automatic triple_t levels_of(state_t s);
    triple_t t;
    case (s)
      3'd0:    t = '{LVL_LOW,  LVL_MID,  LVL_HIGH};
      3'd1:    t = '{LVL_LOW,  LVL_HIGH, LVL_MID };
      3'd2:    t = '{LVL_MID,  LVL_HIGH, LVL_LOW };
      3'd3:    t = '{LVL_HIGH, LVL_MID,  LVL_LOW };
      3'd4:    t = '{LVL_HIGH, LVL_LOW,  LVL_MID };
      default: t = '{LVL_MID,  LVL_LOW,  LVL_HIGH};
    endcase
    return t;
  endfunction
endpackage

// File: rtl/tw_state_step.sv
module tw_state_step
  import tw_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  state_t           cur,
  input  logic [SYM_W-1:0] sym,
  output logic             legal,
  output state_t           nxt
);
  localparam int SUM_W = STATE_W + 1;

  logic [SUM_W-1:0] sum;

  always_comb begin
    legal = (int'(sym) < NUM_SYMS);
    sum   = SUM_W'(cur) + SUM_W'(sym[STATE_W-1:0]) + SUM_W'(1);
    if (sum >= SUM_W'(NUM_STATES)) sum = sum - SUM_W'(NUM_STATES);
    nxt = state_t'(sum);
  end
endmodule

// File: rtl/tw_wire_drive.sv
module tw_wire_drive
  import tw_pkg::*;
(
  input  state_t                st,
  output logic [NUM_WIRES-1:0]  pu,
  output logic [NUM_WIRES-1:0]  pd
);
  triple_t lv;
  assign lv = levels_of(st);

  for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
    assign pu[w] = lv[w][1];
    assign pd[w] = lv[w][0];
  end
endmodule

// File: rtl/tri_wire_encoder.sv
module tri_wire_encoder
  import tw_pkg::*;
#(
  parameter int SYM_W     = 3,
  parameter int RST_STATE = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  output logic [2:0]       wire_pu,
  output logic [2:0]       wire_pd,
  output logic             sym_active,
  output logic [2:0]       state_out
);
  state_t           cur_q, nxt_st, sel_st;
  logic             legal, take;
  logic [2:0]       pu_n, pd_n;

  tw_state_step #(.SYM_W(SYM_W)) u_step (
    .cur(cur_q), .sym(sym_data), .legal(legal), .nxt(nxt_st)
  );

  assign take   = sym_valid && sym_ready && legal;
  assign sel_st = rst ? state_t'(RST_STATE) : (take ? nxt_st : cur_q);

  tw_wire_drive u_drv (.st(sel_st), .pu(pu_n), .pd(pd_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_ready  <= 1'b0;
      sym_active <= 1'b0;
    end else begin
      sym_ready  <= 1'b1;
      sym_active <= take;
    end
    cur_q   <= sel_st;
    wire_pu <= pu_n;
    wire_pd <= pd_n;
  end

  assign state_out = cur_q;
endmodule

// File: rtl/tri_wire_encoder_chk.sv
module tri_wire_encoder_chk #(
  parameter int SYM_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             sym_valid,
  input logic             sym_ready,
  input logic [SYM_W-1:0] sym_data,
  input logic [2:0]       wire_pu,
  input logic [2:0]       wire_pd,
  input logic             sym_active,
  input logic [2:0]       state_out
);
  logic acc;
  logic [1:0] ca, cb, cc;
  assign acc = sym_valid && sym_ready && (int'(sym_data) < 5);
  assign ca = {wire_pu[0], wire_pd[0]};
  assign cb = {wire_pu[1], wire_pd[1]};
  assign cc = {wire_pu[2], wire_pd[2]};

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_out == 3'd0 && ca == 2'b10 && cb == 2'b11 && cc == 2'b01)); // R1
  AST_NO_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || ((ca != 2'b00) && (cb != 2'b00) && (cc != 2'b00))); // R2
  AST_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    $past(rst) || ((ca != cb) && (cb != cc) && (ca != cc))); // R3
  AST_NEXT_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(acc) |-> (int'(state_out) ==
      ((int'($past(state_out)) + int'($past(sym_data)) + 1) % 6))); // R5
  AST_MOVES: assert property (@(posedge clk) disable iff (rst)
    $past(acc) |-> (sym_active && state_out != $past(state_out))); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(acc) && !$past(rst)) |-> ($stable(state_out) && $stable(wire_pu)
      && $stable(wire_pd) && !sym_active)); // R7
  AST_READY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> sym_ready); // R9
endmodule

bind tri_wire_encoder tri_wire_encoder_chk #(.SYM_W(SYM_W)) u_chk (.*);

// File: tb/tri_wire_encoder_test.sv
`timescale 1ns/1ps
module tri_wire_encoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [2:0] sym_data = 3'd0;
  logic [2:0] wire_pu, wire_pd, state_out;
  logic       sym_active;

  int n_chk = 0;
  int n_fail = 0;
  int exp_st = 0;

  always #2.5 clk = ~clk;

  tri_wire_encoder uut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .wire_pu(wire_pu), .wire_pd(wire_pd),
    .sym_active(sym_active), .state_out(state_out)
  );

  // R4 table as {C,B,A} codes, each {pu,pd}: H=10 L=01 M=11
  function automatic logic [5:0] exp_codes(int s);
    case (s)
      0: return {2'b01, 2'b11, 2'b10};
      1: return {2'b01, 2'b10, 2'b11};
      2: return {2'b11, 2'b10, 2'b01};
      3: return {2'b10, 2'b11, 2'b01};
      4: return {2'b10, 2'b01, 2'b11};
      default: return {2'b11, 2'b01, 2'b10};
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic exp_act);
    logic [5:0] c;
    c = exp_codes(exp_st);
    chk({req, " state"}, int'(state_out), exp_st);
    chk({req, " pu"}, int'(wire_pu), int'({c[5], c[3], c[1]}));
    chk({req, " pd"}, int'(wire_pd), int'({c[4], c[2], c[0]}));
    chk({req, " active"}, int'(sym_active), int'(exp_act));
  endtask

  // one UI: inputs set now (at a negedge), checked at the next negedge
  task automatic drive(input logic v, input int d, input string req);
    logic take;
    sym_valid = v;
    sym_data  = 3'(d);
    take = v && (d < 5);
    @(negedge clk);
    if (take) exp_st = (exp_st + d + 1) % 6;
    chk_out(req, take);
  endtask

  task automatic t_reset;
    rst = 1'b1; sym_valid = 1'b1; sym_data = 3'd2;
    repeat (3) @(negedge clk);
    exp_st = 0;
    chk_out("R1", 1'b0);
    chk("R1 ready", int'(sym_ready), 0);
    rst = 1'b0; sym_valid = 1'b0;
    @(negedge clk);
    chk("R9 ready", int'(sym_ready), 1);
    chk_out("R1 hold", 1'b0);
  endtask

  task automatic t_walk;  // R4 all six states via symbol 0
    for (int i = 0; i < 7; i++) drive(1'b1, 0, "R4");
  endtask

  task automatic t_stream;  // R5 R6 R2 R3 back-to-back incl wrap
    int seq [12] = '{4, 4, 3, 1, 2, 0, 4, 2, 3, 3, 1, 4};
    for (int i = 0; i < 12; i++) drive(1'b1, seq[i], "R5");
    chk("R9 ready b2b", int'(sym_ready), 1);
  endtask

  task automatic t_idle;  // R7
    drive(1'b1, 2, "R6");
    for (int i = 0; i < 3; i++) drive(1'b0, i, "R7");
    drive(1'b1, 1, "R6");
  endtask

  task automatic t_illegal;  // R8
    drive(1'b1, 3, "R5");
    for (int d = 5; d < 8; d++) drive(1'b1, d, "R8");
    drive(1'b1, 4, "R5");
  endtask

  task automatic t_reset_mid;  // R1 again from a nonzero state
    drive(1'b1, 1, "R5");
    t_reset();
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_walk();
    t_stream();
    t_idle();
    t_illegal();
    t_reset_mid();
    t_stream();
    report();
  end
endmodule